// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register and Interrupt Core

This block is the host-facing register layer of a two-channel serial communications controller. A byte-wide bus reaches it through a four-location window. Each channel has one control location and one data location. Control accesses go through a per-channel register pointer. The first control write with the pointer at zero loads the pointer and may issue a command. The next control access reads or writes the selected register, and the pointer then returns to zero. Data writes hand a byte to the transmit side. Data reads return the last byte the receiver delivered.

The core tracks receive and transmit interrupts for both channels, including which kind is in service. It writes a shared interrupt vector, whose value depends on the status-high option. It keeps a pending summary and drives one registered interrupt line for both channels. Soft resets of either channel or both are triggered by writing the reset-control register. Bit-level serialization and baud generation sit outside the block. Channel index 0 is channel B and index 1 is channel A.

Top module: `scc_regcore`

## Requirements
- R1: `bus_addr[2]` selects the channel (0 = B, 1 = A) and `bus_addr[1]` selects data (1) or control (0). An access to one channel leaves the other channel's registers unchanged.
- R2: A control write with the pointer at 0 loads bits 2:0 into the pointer and adds 8 when bits 5:3 equal 001. A control write with a non-zero pointer stores the byte in that write register and clears the pointer. A control read returns the read register at the pointer and clears the pointer. Read registers 12 and 13 mirror write registers 12 and 13.
- R3: After reset, RR0 = 0x44, RR1 = 0x07, and all other read registers are 0. The write registers reset to WR4 = 0x04, WR9 = 0xC0 (status-high off), WR11 = 0x08, WR14 = 0x30 and WR15 = 0xF8 (break interrupt enabled), with all others 0.
- R4: A write to register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A, and 11 resets both, whichever channel the write goes to. That byte is not stored. With bits 7:6 = 00 the byte is stored.
- R5: A data write sets RR0 bit 2 and RR1 bit 0 and raises a transmit interrupt. When WR5 bit 3 is set, the channel's bit of `tx_stb` pulses in the following cycle with the byte on `tx_data`. Otherwise there is no pulse.
- R6: A receive strobe is accepted only when WR3 bit 0 is set and RR0 bit 0 is clear. Acceptance stores the byte, sets RR0 bit 0 and raises a receive interrupt. A data read returns the stored byte, clears RR0 bit 0 and clears the receive interrupt.
- R7: A channel requests an interrupt when WR1 bit 0 is set and at least one of these holds: WR1 bit 1 is set with transmit pending; WR1 bits 4:3 are 01 or 10 with receive pending; or WR15 bit 7 is set with RR0 bit 7. `irq` is the OR of both channels, one cycle after the state that causes it.
- R8: With the owning channel's WR9 bit 4 clear, channel B's RR2 vector is 0x0C for A receive, 0x04 for B receive, 0x08 for A transmit, 0x00 for B transmit and 0x06 after a clear. Resetting channel B sets it to 0.
- R9: With that WR9 bit 4 set, the vector codes are 0x30 for A receive, 0x20 for B receive, 0x10 for A transmit, 0x00 for B transmit and 0x60 after a clear.
- R10: Channel A's RR3 shows pending interrupts: bit 5 A receive, bit 4 A transmit, bit 2 B receive, bit 1 B transmit. Channel B's RR3 reads 0.
- R11: A new receive or transmit interrupt updates the vector only if the other kind is not in service on that channel. Clearing one kind re-raises the other at once if it is still pending.
- R12: Command 101 (0x28) clears the transmit interrupt. Command 111 (0x38) clears the in-service interrupt, receive before transmit.
- R13: A break strobe sets RR0 bit 7, which holds until that channel is reset.
- R14: When a host access and a receive strobe fall in the same cycle, the host access acts first. A data read therefore returns the old byte, and the new byte is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | [2] channel, [1] data/control |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data for the addressed location (combinational) |
| rx_stb | input | 2 | Received-byte strobe per channel (0 = B, 1 = A) |
| rx_data | input | 16 | Received bytes, channel c at [8c+7:8c] |
| brk_stb | input | 2 | Break-detect strobe per channel |
| tx_stb | output | 2 | Transmit byte strobe per channel |
| tx_data | output | 8 | Byte to transmit |
| irq | output | 1 | Shared interrupt request |

## Verification
The hardest state to reach is a receive and a transmit interrupt pending together on one channel with only one of them in service. The stimulus reaches it by raising one kind and then the other before any clear. It then issues the in-service clear twice and checks that the vector follows the handover from the first kind to the second and then to none. A second hard case is a data read that coincides with a receive strobe while the buffer is full. The bench drives both in the same clock and checks that the read returns the old byte and that the new byte is waiting afterwards. The vector codes are swept over both channels and both status-high settings.

// File: rtl/scc_pkg.sv
// Shared types and helpers for the dual-channel serial register core.
// Assumes exactly two channels: index 0 is channel B, index 1 is channel A.
package scc_pkg;
    localparam int NCH = 2;

    // Interrupt tracking: pending and in-service flags per channel plus vector.
    typedef struct packed {
        logic [NCH-1:0] rxp;
        logic [NCH-1:0] txp;
        logic [NCH-1:0] rxs;
        logic [NCH-1:0] txs;
        logic [7:0]     vec;
    } irq_st_t;

    function automatic logic [7:0] vec_rx(input logic is_a, input logic hi);
        if (is_a) return hi ? 8'h30 : 8'h0C;
        return hi ? 8'h20 : 8'h04;
    endfunction

    function automatic logic [7:0] vec_tx(input logic is_a, input logic hi);
        if (is_a) return hi ? 8'h10 : 8'h08;
        return 8'h00;
    endfunction

    function automatic logic [7:0] vec_none(input logic hi);
        return hi ? 8'h60 : 8'h06;
    endfunction

    function automatic irq_st_t irq_set_rx(input irq_st_t s, input logic c, input logic hi);
        irq_st_t t = s;
        t.rxp[c] = 1'b1;
        if (!t.txs[c]) begin
            t.rxs[c] = 1'b1;
            t.vec    = vec_rx(c, hi);
        end
        return t;
    endfunction

    function automatic irq_st_t irq_set_tx(input irq_st_t s, input logic c, input logic hi);
        irq_st_t t = s;
        t.txp[c] = 1'b1;
        if (!t.rxs[c]) begin
            t.txs[c] = 1'b1;
            t.vec    = vec_tx(c, hi);
        end
        return t;
    endfunction

    function automatic irq_st_t irq_clr_rx(input irq_st_t s, input logic c, input logic hi);
        irq_st_t t = s;
        t.rxp[c] = 1'b0;
        t.rxs[c] = 1'b0;
        t.vec    = vec_none(hi);
        if (t.txp[c]) t = irq_set_tx(t, c, hi);
        return t;
    endfunction

    function automatic irq_st_t irq_clr_tx(input irq_st_t s, input logic c, input logic hi);
        irq_st_t t = s;
        t.txp[c] = 1'b0;
        t.txs[c] = 1'b0;
        t.vec    = vec_none(hi);
        if (t.rxp[c]) t = irq_set_rx(t, c, hi);
        return t;
    endfunction
endpackage

// File: rtl/scc_chan.sv
// One channel's register bank: pointer, write registers, RR0/RR1, receive byte.
// Assumes the top presents at most one host access per cycle and resolves
// soft-reset requests from both channels into soft_rst.
module scc_chan #(
    parameter bit IS_A = 1'b0,
    parameter int DW   = 8,
    parameter int NREG = 16,
    localparam int PW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic          rd,
    input  logic          is_data,
    input  logic [DW-1:0] wdata,
    input  logic          soft_rst,
    input  logic          rx_stb,
    input  logic [DW-1:0] rx_byte,
    input  logic          brk_stb,
    input  logic          rx_pend,
    input  logic          tx_pend,
    input  logic [DW-1:0] ext_rr2,
    input  logic [DW-1:0] ext_rr3,
    output logic [DW-1:0] rdata,
    output logic [1:0]    rst_code,
    output logic          cmd_clr_tx,
    output logic          cmd_clr_ius,
    output logic          data_wr,
    output logic          data_rd,
    output logic          rx_acc,
    output logic          tx_fire,
    output logic          hi,
    output logic          master_en,
    output logic          req
);
    localparam int REG_IE   = 1;
    localparam int REG_RXC  = 3;
    localparam int REG_TXC  = 5;
    localparam int REG_RST  = 9;
    localparam int REG_BLO  = 12;
    localparam int REG_BHI  = 13;
    localparam int REG_XIE  = 15;
    localparam logic [2:0] CMD_HI  = 3'd1;
    localparam logic [2:0] CMD_CTX = 3'd5;
    localparam logic [2:0] CMD_IUS = 3'd7;

    function automatic logic [DW-1:0] wr_init(input int i);
        case (i)
            4:       return DW'(8'h04);
            9:       return DW'(8'hC0);
            11:      return DW'(8'h08);
            14:      return DW'(8'h30);
            15:      return DW'(8'hF8);
            default: return '0;
        endcase
    endfunction

    logic [DW-1:0] wr_q [NREG];
    logic [DW-1:0] wr_n [NREG];
    logic [PW-1:0] ptr_q, ptr_n;
    logic [DW-1:0] rr0_q, rr0_n, rr1_q, rr1_n, rxd_q, rxd_n;
    logic          ctl_wr, ctl_rd, at_zero;
    logic [2:0]    cmd;

    // Decode this channel's share of the host access.
    always_comb begin
        ctl_wr      = sel && wr && !is_data;
        ctl_rd      = sel && rd && !is_data;
        data_wr     = sel && wr && is_data;
        data_rd     = sel && rd && is_data;
        at_zero     = (ptr_q == '0);
        cmd         = wdata[5:3];
        cmd_clr_tx  = ctl_wr && at_zero && (cmd == CMD_CTX);
        cmd_clr_ius = ctl_wr && at_zero && (cmd == CMD_IUS);
        rst_code    = (ctl_wr && ptr_q == PW'(REG_RST)) ? wdata[7:6] : 2'b00;
        tx_fire     = data_wr && wr_q[REG_TXC][3];
    end

    // Next state in order: host access, break, soft reset, then receiver.
    always_comb begin
        wr_n  = wr_q;
        ptr_n = ptr_q;
        rr0_n = rr0_q;
        rr1_n = rr1_q;
        rxd_n = rxd_q;
        if (ctl_wr) begin
            if (at_zero) begin
                ptr_n = PW'(wdata[2:0]) | ((cmd == CMD_HI) ? PW'(8) : PW'(0));
            end else begin
                if (ptr_q != PW'(REG_RST) || wdata[7:6] == 2'b00)
                    wr_n[ptr_q] = wdata;
                ptr_n = '0;
            end
        end
        if (ctl_rd) ptr_n = '0;
        if (data_wr) begin
            rr0_n[2] = 1'b1;
            rr1_n[0] = 1'b1;
        end
        if (data_rd) rr0_n[0] = 1'b0;
        if (brk_stb) rr0_n[7] = 1'b1;
        if (soft_rst) begin
            for (int i = 0; i < NREG; i++) wr_n[i] = wr_init(i);
            ptr_n = '0;
            rr0_n = DW'(8'h44);
            rr1_n = DW'(8'h07);
            rxd_n = '0;
        end
        rx_acc = rx_stb && wr_n[REG_RXC][0] && !rr0_n[0];
        if (rx_acc) begin
            rr0_n[0] = 1'b1;
            rxd_n    = rx_byte;
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) wr_q[i] <= wr_init(i);
            ptr_q <= '0;
            rr0_q <= DW'(8'h44);
            rr1_q <= DW'(8'h07);
            rxd_q <= '0;
        end else begin
            wr_q  <= wr_n;
            ptr_q <= ptr_n;
            rr0_q <= rr0_n;
            rr1_q <= rr1_n;
            rxd_q <= rxd_n;
        end
    end

    // Read mux: data location returns the receive byte, control the pointed register.
    always_comb begin
        if (is_data) begin
            rdata = rxd_q;
        end else begin
            case (int'(ptr_q))
                0:       rdata = rr0_q;
                1:       rdata = rr1_q;
                2:       rdata = IS_A ? '0 : ext_rr2;
                3:       rdata = IS_A ? ext_rr3 : '0;
                REG_BLO: rdata = wr_q[REG_BLO];
                REG_BHI: rdata = wr_q[REG_BHI];
                default: rdata = '0;
            endcase
        end
    end

    // Interrupt request of this channel.
    always_comb begin
        hi        = wr_q[REG_RST][4];
        master_en = wr_q[REG_IE][0];
        req = master_en &&
              ((wr_q[REG_IE][1] && tx_pend) ||
               ((wr_q[REG_IE][4:3] == 2'b01 || wr_q[REG_IE][4:3] == 2'b10) && rx_pend) ||
               (wr_q[REG_XIE][7] && rr0_q[7]));
    end

    p_ptr_clear_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd |=> (ptr_q == '0));
    p_rx_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_acc |=> rr0_q[0]);
    p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rr0_q[0] && !data_rd && !soft_rst) |=> (rr0_q[0] && $stable(rxd_q)));
    p_soft_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (rr0_q == DW'(8'h44) && wr_q[REG_RST] == DW'(8'hC0)));
endmodule

// File: rtl/scc_irq.sv
// Interrupt pending/in-service tracker shared by both channels.
// Applies events in a fixed order each cycle: host commands, soft resets,
// then receive acceptances; it assumes one host access per cycle.
module scc_irq
    import scc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] h_clr_tx,
    input  logic [NCH-1:0] h_clr_ius,
    input  logic [NCH-1:0] h_set_tx,
    input  logic [NCH-1:0] h_clr_rx,
    input  logic [NCH-1:0] soft_rst,
    input  logic [NCH-1:0] rx_acc,
    input  logic [NCH-1:0] hi,
    output logic [NCH-1:0] rx_pend,
    output logic [NCH-1:0] tx_pend,
    output logic [7:0]     vec,
    output logic [7:0]     pend_bits
);
    irq_st_t st_q, st_n;

    // Ordered next-state of the interrupt flags and vector.
    always_comb begin
        st_n = st_q;
        for (int c = 0; c < NCH; c++) begin
            if (h_clr_tx[c]) st_n = irq_clr_tx(st_n, 1'(c), hi[c]);
            if (h_clr_ius[c]) begin
                if (st_n.rxs[c])      st_n = irq_clr_rx(st_n, 1'(c), hi[c]);
                else if (st_n.txs[c]) st_n = irq_clr_tx(st_n, 1'(c), hi[c]);
            end
            if (h_set_tx[c]) st_n = irq_set_tx(st_n, 1'(c), hi[c]);
            if (h_clr_rx[c]) st_n = irq_clr_rx(st_n, 1'(c), hi[c]);
        end
        for (int c = 0; c < NCH; c++) begin
            if (soft_rst[c]) begin
                st_n.rxp[c] = 1'b0;
                st_n.txp[c] = 1'b0;
                st_n.rxs[c] = 1'b0;
                st_n.txs[c] = 1'b0;
            end
        end
        if (soft_rst[0]) st_n.vec = 8'h00;
        for (int c = 0; c < NCH; c++) begin
            if (rx_acc[c]) st_n = irq_set_rx(st_n, 1'(c), hi[c]);
        end
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_n;
    end

    // Outputs: pending summary laid out for channel A's RR3.
    always_comb begin
        rx_pend   = st_q.rxp;
        tx_pend   = st_q.txp;
        vec       = st_q.vec;
        pend_bits = {2'b00, st_q.rxp[1], st_q.txp[1], 1'b0, st_q.rxp[0], st_q.txp[0], 1'b0};
    end

    p_ius_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rxs & st_q.txs) == '0);
    p_ius_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.rxs & ~st_q.rxp) | (st_q.txs & ~st_q.txp)) == '0);
endmodule

// File: rtl/scc_regcore.sv
// Top of the dual-channel register and interrupt core. Decodes the bus window,
// instantiates both channel banks and the interrupt tracker, routes soft resets,
// and registers the transmit strobe and the interrupt line.
module scc_regcore
    import scc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:1]   bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    input  logic [1:0]   rx_stb,
    input  logic [15:0]  rx_data,
    input  logic [1:0]   brk_stb,
    output logic [1:0]   tx_stb,
    output logic [7:0]   tx_data,
    output logic         irq
);
    logic [7:0]     ch_rdata [NCH];
    logic [1:0]     rst_code [NCH];
    logic [NCH-1:0] clr_tx, clr_ius, dat_wr, dat_rd, rx_acc, tx_fire, hi, master_en, req;
    logic [NCH-1:0] soft_rst, rx_pend, tx_pend;
    logic [7:0]     vec, pend_bits;
    logic [NCH-1:0] tx_stb_q;
    logic [7:0]     tx_q;
    logic           irq_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        scc_chan #(.IS_A(c == 1)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (bus_addr[2] == 1'(c)),
            .wr         (bus_wr),
            .rd         (bus_rd),
            .is_data    (bus_addr[1]),
            .wdata      (bus_wdata),
            .soft_rst   (soft_rst[c]),
            .rx_stb     (rx_stb[c]),
            .rx_byte    (rx_data[8*c +: 8]),
            .brk_stb    (brk_stb[c]),
            .rx_pend    (rx_pend[c]),
            .tx_pend    (tx_pend[c]),
            .ext_rr2    (vec),
            .ext_rr3    (pend_bits),
            .rdata      (ch_rdata[c]),
            .rst_code   (rst_code[c]),
            .cmd_clr_tx (clr_tx[c]),
            .cmd_clr_ius(clr_ius[c]),
            .data_wr    (dat_wr[c]),
            .data_rd    (dat_rd[c]),
            .rx_acc     (rx_acc[c]),
            .tx_fire    (tx_fire[c]),
            .hi         (hi[c]),
            .master_en  (master_en[c]),
            .req        (req[c])
        );
    end

    // Reset-control byte bit 6 targets channel B, bit 7 channel A, from either channel.
    always_comb begin
        soft_rst[0] = rst_code[0][0] | rst_code[1][0];
        soft_rst[1] = rst_code[0][1] | rst_code[1][1];
        bus_rdata   = ch_rdata[bus_addr[2]];
    end

    scc_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_clr_tx (clr_tx),
        .h_clr_ius(clr_ius),
        .h_set_tx (dat_wr),
        .h_clr_rx (dat_rd),
        .soft_rst (soft_rst),
        .rx_acc   (rx_acc),
        .hi       (hi),
        .rx_pend  (rx_pend),
        .tx_pend  (tx_pend),
        .vec      (vec),
        .pend_bits(pend_bits)
    );

    // Output registers for the transmit strobe, byte and interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_stb_q <= '0;
            tx_q     <= '0;
            irq_q    <= 1'b0;
        end else begin
            tx_stb_q <= tx_fire;
            if (|tx_fire) tx_q <= bus_wdata;
            irq_q    <= |req;
        end
    end

    assign tx_stb  = tx_stb_q;
    assign tx_data = tx_q;
    assign irq     = irq_q;

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en == '0) |=> !irq_q);
    p_tx_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_stb_q));
endmodule

// File: tb/scc_regcore_tb.sv
module scc_regcore_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:1]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  rx_stb = '0;
    logic [15:0] rx_data = '0;
    logic [1:0]  brk_stb = '0;
    logic [1:0]  tx_stb;
    logic [7:0]  tx_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [1:0] last_tx;
    logic [7:0] q;

    always #10 clk = ~clk;

    scc_regcore u_dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle; starts and ends just after a falling edge.
    task automatic bus(input logic [1:0] a, input logic w, input logic r,
                       input logic [7:0] d, output logic [7:0] rq);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        #5 rq = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        last_tx = tx_stb;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic cmd(input int c, input logic [7:0] v);
        logic [7:0] t; bus({1'(c), 1'b0}, 1'b1, 1'b0, v, t);
    endtask

    task automatic setptr(input int c, input int r);
        if (r != 0) cmd(c, 8'((r & 7) | ((r >= 8) ? 8 : 0)));
    endtask

    task automatic wreg(input int c, input int r, input logic [7:0] v);
        setptr(c, r); cmd(c, v);
    endtask

    task automatic rreg(input int c, input int r, output logic [7:0] v);
        setptr(c, r); bus({1'(c), 1'b0}, 1'b0, 1'b1, 8'h00, v);
    endtask

    task automatic datw(input int c, input logic [7:0] v);
        logic [7:0] t; bus({1'(c), 1'b1}, 1'b1, 1'b0, v, t);
    endtask

    task automatic datr(input int c, output logic [7:0] v);
        bus({1'(c), 1'b1}, 1'b0, 1'b1, 8'h00, v);
    endtask

    task automatic rx(input int c, input logic [7:0] b);
        rx_stb[c] = 1'b1; rx_data[8*c +: 8] = b;
        @(posedge clk); @(negedge clk);
        rx_stb = '0;
    endtask

    function automatic logic [7:0] ev(input int kind, input int c, input int hi);
        // kind 0 = receive, 1 = transmit, 2 = none
        if (kind == 2) return hi ? 8'h60 : 8'h06;
        if (kind == 1) return (c == 1) ? (hi ? 8'h10 : 8'h08) : 8'h00;
        return (c == 1) ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
    endfunction

    initial begin
        #(20 * 200000);
        checks++; failures++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R3: reset values of every read register on both channels
        chk("R3 irq", {7'd0, irq}, 8'h00);
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 16; r++) begin
                rreg(c, r, q);
                chk("R3 rr", q, (r == 0) ? 8'h44 : (r == 1) ? 8'h07 : 8'h00);
            end

        // R1/R2: pointer access, mirror registers, channel isolation
        for (int v = 0; v < 4; v++) begin
            wreg(0, 12, 8'(8'h11 * v + 3));
            wreg(0, 13, 8'(~(8'h11 * v + 3)));
            wreg(1, 12, 8'(8'h5A ^ v));
            rreg(0, 12, q); chk("R2 rr12 B", q, 8'(8'h11 * v + 3));
            rreg(0, 13, q); chk("R2 rr13 B", q, 8'(~(8'h11 * v + 3)));
            rreg(1, 12, q); chk("R1 rr12 A", q, 8'(8'h5A ^ v));
        end
        setptr(1, 12);
        bus(2'b10, 1'b0, 1'b1, 8'h00, q); chk("R2 pointed read", q, 8'h5A ^ 8'h03);
        bus(2'b10, 1'b0, 1'b1, 8'h00, q); chk("R2 ptr back to 0", q, 8'h44);

        // R4: targeted soft resets; bits 7:6 = 00 stores
        wreg(1, 9, 8'h40);
        rreg(0, 12, q); chk("R4 B reset", q, 8'h00);
        rreg(1, 12, q); chk("R4 A kept", q, 8'h59);
        wreg(0, 9, 8'h80);
        rreg(1, 12, q); chk("R4 A reset", q, 8'h00);

        // R8/R9/R10/R7/R6/R5/R12: vector sweep over channel and status-high
        for (int h = 0; h < 2; h++)
            for (int c = 0; c < 2; c++) begin
                wreg(0, 9, 8'hC0);
                wreg(c, 9, h ? 8'h10 : 8'h00);
                wreg(c, 3, 8'h01);
                wreg(c, 1, 8'h13);
                rx(c, 8'(8'hA0 + 2 * h + c));
                rreg(0, 2, q); chk(h ? "R9 rx vec" : "R8 rx vec", q, ev(0, c, h));
                rreg(1, 3, q); chk("R10 rx pend", q, c ? 8'h20 : 8'h04);
                rreg(0, 3, q); chk("R10 B rr3", q, 8'h00);
                chk("R7 irq rx", {7'd0, irq}, 8'h01);
                rreg(c, 0, q); chk("R6 rxav", q, 8'h45);
                datr(c, q); chk("R6 data", q, 8'(8'hA0 + 2 * h + c));
                rreg(c, 0, q); chk("R6 rxav clr", q, 8'h44);
                rreg(0, 2, q); chk(h ? "R9 none vec" : "R8 none vec", q, ev(2, c, h));
                datw(c, 8'h3C);
                chk("R5 no strobe", {6'd0, last_tx}, 8'h00);
                rreg(0, 2, q); chk(h ? "R9 tx vec" : "R8 tx vec", q, ev(1, c, h));
                rreg(1, 3, q); chk("R10 tx pend", q, c ? 8'h10 : 8'h02);
                rreg(c, 1, q); chk("R5 rr1", q, 8'h07);
                cmd(c, 8'h28);
                rreg(1, 3, q); chk("R12 clr tx", q, 8'h00);
                idle(1);
                chk("R7 irq idle", {7'd0, irq}, 8'h00);
            end

        // R5: transmit enabled
        wreg(0, 9, 8'hC0);
        for (int c = 0; c < 2; c++) begin
            wreg(c, 5, 8'h08);
            datw(c, 8'(8'h70 + c));
            chk("R5 strobe", {6'd0, last_tx}, 8'(1 << c));
            chk("R5 byte", tx_data, 8'(8'h70 + c));
        end

        // R11/R12: in-service arbitration on channel A, rx first then tx
        wreg(0, 9, 8'hC0);
        wreg(1, 3, 8'h01); wreg(1, 1, 8'h13);
        rx(1, 8'h11);
        datw(1, 8'h22);
        rreg(0, 2, q); chk("R11 vec held rx", q, 8'h0C);
        rreg(1, 3, q); chk("R11 both pend", q, 8'h30);
        cmd(1, 8'h38);
        rreg(0, 2, q); chk("R12 ius rx first", q, 8'h08);
        rreg(1, 3, q); chk("R11 tx remains", q, 8'h10);
        rreg(1, 0, q); chk("R12 rxav kept", q, 8'h45);
        cmd(1, 8'h38);
        rreg(0, 2, q); chk("R12 ius tx", q, 8'h06);
        datr(1, q);
        // tx first then rx, clear tx re-raises rx
        datw(1, 8'h33);
        rx(1, 8'h44);
        rreg(0, 2, q); chk("R11 vec held tx", q, 8'h08);
        cmd(1, 8'h28);
        rreg(0, 2, q); chk("R11 re-raise rx", q, 8'h0C);

        // R6: acceptance rules; R14: same-cycle read and receive
        wreg(0, 9, 8'hC0);
        rx(0, 8'h21);
        rreg(0, 0, q); chk("R6 rx disabled", q, 8'h44);
        wreg(0, 3, 8'h01);
        rx(0, 8'h31);
        rx(0, 8'h32);
        rx_stb[0] = 1'b1; rx_data[7:0] = 8'h55;
        datr(0, q);
        rx_stb = '0;
        chk("R14 old byte", q, 8'h31);
        rreg(0, 0, q); chk("R14 new avail", q, 8'h45);
        datr(0, q); chk("R14 new byte", q, 8'h55);

        // R13/R7/R3: break with default break enable, masking, reset clears
        wreg(0, 9, 8'hC0);
        brk_stb[0] = 1'b1; idle(1); brk_stb = '0;
        idle(1);
        chk("R7 masked brk", {7'd0, irq}, 8'h00);
        rreg(0, 0, q); chk("R13 brk flag", q, 8'hC4);
        wreg(0, 1, 8'h01);
        idle(1);
        chk("R13 brk irq", {7'd0, irq}, 8'h01);
        rreg(1, 0, q); chk("R1 A no brk", q, 8'h44);
        wreg(0, 15, 8'h00);
        idle(1);
        chk("R13 brk disabled", {7'd0, irq}, 8'h00);
        wreg(0, 9, 8'h40);
        rreg(0, 0, q); chk("R13 reset clears", q, 8'h44);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule